// File: doc/BRIEF.md
# Shared-Bus Cycle Classifier and Sub-Word Memory Port

This block sits between a 32-bit core that fetches instructions and moves data over one shared bus, and a small synchronous memory. Each clock the core presents one request: whether it wants a memory transfer, whether a non-transfer cycle belongs to a coprocessor, the address, the direction, the access size and a flag marking the two halves of an atomic swap. The block turns that request into a two-bit cycle-type code, one enable per byte lane, a bus lock and an abort for illegal requests.

The cycle-type code tells the memory system whether the address continues from the previous transfer, so a controller can use a faster burst access. The block compares each transfer address with the one it saw last. Lane enables follow the access size, the low address bits and an endian configuration input. The attached memory applies the lane enables to writes, and returns sub-word reads zero-extended in the low bits of the read bus. The swap flag keeps the lock asserted from the read half to the write half, so no other master can get in between.

Top module: `bus_cycle_unit`

## Requirements
- R1: The cycle code is the pair (memIdle, cycSeq). A transfer drives memIdle=0. A non-transfer cycle drives (1,0) when reqCopro=0, meaning internal, and (1,1) when reqCopro=1, meaning a coprocessor transfer. In both non-transfer cases laneEn is 0 and the memory is not touched.
- R2: A transfer drives cycSeq=1 exactly when the previous cycle was also a transfer and the address equals that transfer's address, or exceeds it by 2 or by 4 (modulo 2^32). Otherwise it drives cycSeq=0.
- R3: The first transfer after reset is non-sequential, even at address 0. So is the first transfer after any internal or coprocessor cycle.
- R4: reqSize encodes 00 byte, 01 halfword, 10 word. A transfer raises abort combinationally when the size is 11, when a halfword has addr[0]=1, or when a word has addr[1:0]≠0. A non-transfer never aborts.
- R5: An aborted transfer drives laneEn=0, leaves every memory byte unchanged and does not update rdData. It still counts as the previous transfer for R2.
- R6: With bigEndian=0, a byte access enables lane addr[1:0], where lane k is bus bits 8k+7:8k. A halfword enables lanes 1:0 when addr[1]=0 and lanes 3:2 when addr[1]=1. A word enables all four lanes.
- R7: With bigEndian=1, a byte access enables lane 3−addr[1:0]. A halfword enables lanes 3:2 when addr[1]=0 and lanes 1:0 when addr[1]=1. A word enables all four lanes.
- R8: A write places the low 8, 16 or 32 bits of wrData into the enabled lanes, lowest byte into the lowest enabled lane. All other bytes are unchanged. The memory word is selected by address bits [7:2] with the default depth of 64 words, and higher bits alias.
- R9: A non-aborted read updates rdData in the following cycle. rdData holds the enabled lanes shifted down to bit 0 and zero-extended, and it keeps its value until the next such read.
- R10: busLock is 1 in any transfer cycle that carries reqSwap and does not abort. After a non-aborted swap read it stays 1 in every cycle, including any internal ones, up to and including the next write transfer. It falls after that write.
- R11: Right after reset busLock=0 and rdData=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqXfer | input | 1 | Request is a memory transfer |
| reqCopro | input | 1 | Non-transfer cycle is a coprocessor transfer |
| reqAddr | input | 32 | Byte address |
| reqWrite | input | 1 | 1 write, 0 read |
| reqSize | input | 2 | Access size code |
| reqSwap | input | 1 | Transfer belongs to an atomic swap |
| bigEndian | input | 1 | Lane order select |
| wrData | input | 32 | Write data, sub-word in the low bits |
| memIdle | output | 1 | Cycle-type bit: no memory transfer |
| cycSeq | output | 1 | Cycle-type bit: sequential or coprocessor |
| laneEn | output | 4 | Byte lane enables |
| busLock | output | 1 | Bus lock for swaps |
| abort | output | 1 | Illegal size or misalignment |
| rdData | output | 32 | Read data, zero-extended |

## Verification
The bench targets the address-compare edges: a repeated address, steps of +2 and +4, a step of +8 or a backward step, a 32-bit wrap from 0xFFFFFFFC to 0, and the first transfer after reset or after an internal cycle. A classifier that kept stale history, or that left out the +2 case, would report the wrong burst type there. It reads back the same word as bytes and halfwords in both endian settings, so a reversed or shifted lane map shows up as a wrong byte. Misaligned and reserved-size writes are followed by reads of the targeted word, which expose any write that was not suppressed. Swaps separated by internal cycles show whether the lock drops early or stays stuck after the write.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic       wrEn;
    logic       rdEn;
    logic [3:0] laneEn;
    logic [1:0] lowLane;
    logic [1:0] size;
  } memStrobe_t;

endpackage

// File: rtl/lane_decode.sv
module lane_decode
  import bus_cycle_pkg::*;
(
  input  logic [1:0] addrLo,
  input  logic [1:0] size,
  input  logic       bigEndian,
  output logic [3:0] laneMask,
  output logic [1:0] lowLane
);

  // Each physical lane works out its logical byte position and tests itself.
  for (genvar lane = 0; lane < 4; lane++) begin : g_lane
    logic [1:0] logicalPos;
    assign logicalPos = bigEndian ? 2'(3 - lane) : 2'(lane);
    always_comb begin
      unique case (accSize_e'(size))
        SZ_BYTE: laneMask[lane] = (logicalPos == addrLo);
        SZ_HALF: laneMask[lane] = (logicalPos[1] == addrLo[1]);
        SZ_WORD: laneMask[lane] = 1'b1;
        default: laneMask[lane] = 1'b0;
      endcase
    end
  end

  // Lowest enabled physical lane, used to align sub-word data
  always_comb begin
    unique case (accSize_e'(size))
      SZ_BYTE: lowLane = bigEndian ? ~addrLo : addrLo;
      SZ_HALF: lowLane = {addrLo[1] ^ bigEndian, 1'b0};
      default: lowLane = 2'b00;
    endcase
  end

endmodule

// File: rtl/cycle_ctrl.sv
module cycle_ctrl
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqXfer,
  input  logic              reqCopro,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic              reqSwap,
  input  logic              bigEndian,
  output logic              memIdle,
  output logic              cycSeq,
  output logic              busLock,
  output logic              abort,
  output memStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] STEP_HALF = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(4);

  logic [ADDR_W-1:0] prevAddr;
  logic              prevValid;
  logic              lockHeld;
  logic              misalign;
  logic              nearPrev;
  logic [3:0]        laneMask;
  logic [1:0]        lowLane;
  logic              goXfer;

  lane_decode u_lanes (
    .addrLo   (reqAddr[1:0]),
    .size     (reqSize),
    .bigEndian(bigEndian),
    .laneMask (laneMask),
    .lowLane  (lowLane)
  );

  always_comb begin
    unique case (accSize_e'(reqSize))
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = reqAddr[0];
      SZ_WORD: misalign = |reqAddr[1:0];
      default: misalign = 1'b1;
    endcase
  end

  assign abort  = reqXfer & misalign;
  assign goXfer = reqXfer & ~misalign;

  assign nearPrev = (reqAddr == prevAddr) ||
                    (reqAddr == prevAddr + STEP_HALF) ||
                    (reqAddr == prevAddr + STEP_WORD);

  assign memIdle = ~reqXfer;
  assign cycSeq  = reqXfer ? (prevValid & nearPrev) : reqCopro;
  assign busLock = lockHeld | (goXfer & reqSwap);

  assign strobe.wrEn    = goXfer & reqWrite;
  assign strobe.rdEn    = goXfer & ~reqWrite;
  assign strobe.laneEn  = goXfer ? laneMask : 4'b0000;
  assign strobe.lowLane = lowLane;
  assign strobe.size    = reqSize;

  // Address history: every transfer is remembered, any other cycle clears it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevAddr  <= '0;
      prevValid <= 1'b0;
    end else if (reqXfer) begin
      prevAddr  <= reqAddr;
      prevValid <= 1'b1;
    end else begin
      prevValid <= 1'b0;
    end
  end

  // Swap lock: set by the read half, released after a write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockHeld <= 1'b0;
    end else if (goXfer && reqSwap && !reqWrite) begin
      lockHeld <= 1'b1;
    end else if (reqXfer && reqWrite) begin
      lockHeld <= 1'b0;
    end
  end

endmodule

// File: rtl/mem_path.sv
module mem_path
  import bus_cycle_pkg::*;
#(
  parameter int MEM_WORDS = 64,
  parameter int DATA_W    = 32
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  memStrobe_t                   strobe,
  input  logic [$clog2(MEM_WORDS)-1:0] wordIdx,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] memArr [MEM_WORDS];
  logic [DATA_W-1:0] wrAligned;
  logic [DATA_W-1:0] rdWordQ;
  logic [1:0]        rdShiftQ;
  logic [1:0]        rdSizeQ;
  logic [DATA_W-1:0] rdShifted;

  assign wrAligned = wrData << {strobe.lowLane, 3'b000};

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int lane = 0; lane < LANES; lane++) begin
        if (strobe.laneEn[lane]) begin
          memArr[wordIdx][lane*8 +: 8] <= wrAligned[lane*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdWordQ  <= '0;
      rdShiftQ <= 2'b00;
      rdSizeQ  <= SZ_WORD;
    end else if (strobe.rdEn) begin
      rdWordQ  <= memArr[wordIdx];
      rdShiftQ <= strobe.lowLane;
      rdSizeQ  <= strobe.size;
    end
  end

  assign rdShifted = rdWordQ >> {rdShiftQ, 3'b000};

  always_comb begin
    unique case (accSize_e'(rdSizeQ))
      SZ_BYTE: rdData = {{(DATA_W-8){1'b0}},  rdShifted[7:0]};
      SZ_HALF: rdData = {{(DATA_W-16){1'b0}}, rdShifted[15:0]};
      default: rdData = rdShifted;
    endcase
  end

endmodule

// File: rtl/bus_cycle_unit.sv
module bus_cycle_unit
  import bus_cycle_pkg::*;
#(
  parameter int MEM_WORDS = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqXfer,
  input  logic        reqCopro,
  input  logic [31:0] reqAddr,
  input  logic        reqWrite,
  input  logic [1:0]  reqSize,
  input  logic        reqSwap,
  input  logic        bigEndian,
  input  logic [31:0] wrData,
  output logic        memIdle,
  output logic        cycSeq,
  output logic [3:0]  laneEn,
  output logic        busLock,
  output logic        abort,
  output logic [31:0] rdData
);

  localparam int IDX_W = $clog2(MEM_WORDS);

  memStrobe_t strobe;

  cycle_ctrl #(.ADDR_W(32)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqXfer  (reqXfer),
    .reqCopro (reqCopro),
    .reqAddr  (reqAddr),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqSwap  (reqSwap),
    .bigEndian(bigEndian),
    .memIdle  (memIdle),
    .cycSeq   (cycSeq),
    .busLock  (busLock),
    .abort    (abort),
    .strobe   (strobe)
  );

  mem_path #(.MEM_WORDS(MEM_WORDS), .DATA_W(32)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wordIdx(reqAddr[2 +: IDX_W]),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign laneEn = strobe.laneEn;

endmodule

// File: rtl/bus_cycle_unit_chk.sv
module bus_cycle_unit_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqXfer,
  input logic        reqSwap,
  input logic        reqWrite,
  input logic [31:0] reqAddr,
  input logic        memIdle,
  input logic        cycSeq,
  input logic [3:0]  laneEn,
  input logic        busLock,
  input logic        abort
);

  AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rstN)
    memIdle |-> (laneEn == 4'b0000)); // R1

  AST_REPEAT_IS_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    (!memIdle && !$past(memIdle) && reqAddr == $past(reqAddr)) |-> cycSeq); // R2

  AST_NO_SEQ_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memIdle && $past(memIdle)) |-> !cycSeq); // R3

  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    abort |-> (laneEn == 4'b0000 && !memIdle)); // R5

  AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rstN)
    (!memIdle && !abort) |-> ($countones(laneEn) == 1 || $countones(laneEn) == 2
                              || $countones(laneEn) == 4)); // R6

  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (reqXfer && reqSwap && !reqWrite && !abort) |=> busLock); // R10

endmodule

bind bus_cycle_unit bus_cycle_unit_chk u_chk (.*);

// File: tb/bus_cycle_unit_tb.sv
module bus_cycle_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqXfer = 1'b0, reqCopro = 1'b0, reqWrite = 1'b0, reqSwap = 1'b0;
  logic        bigEndian = 1'b0;
  logic [31:0] reqAddr = '0, wrData = '0;
  logic [1:0]  reqSize = 2'b10;
  logic        memIdle, cycSeq, busLock, abort;
  logic [3:0]  laneEn;
  logic [31:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic [31:0] refMem [64];
  logic [31:0] refPrev = '0;
  bit          refPrevOk = 0;
  bit          refLock = 0;
  logic [31:0] refRd = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_unit u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit isBad(logic [1:0] sz, logic [31:0] a);
    return (sz == 2'b11) || (sz == 2'b01 && a[0]) || (sz == 2'b10 && a[1:0] != 2'b00);
  endfunction

  function automatic logic [1:0] firstLane(logic [1:0] sz, logic [31:0] a, bit be);
    if (sz == 2'b00) return be ? 2'(3 - a[1:0]) : a[1:0];
    if (sz == 2'b01) return be ? (a[1] ? 2'd0 : 2'd2) : (a[1] ? 2'd2 : 2'd0);
    return 2'd0;
  endfunction

  function automatic logic [3:0] lanesOf(logic [1:0] sz, logic [31:0] a, bit be);
    logic [1:0] f = firstLane(sz, a, be);
    if (sz == 2'b00) return 4'b0001 << f;
    if (sz == 2'b01) return 4'b0011 << f;
    return 4'b1111;
  endfunction

  task automatic step(bit x, bit cp, logic [31:0] a, bit w, logic [1:0] sz,
                      bit sw, bit be, logic [31:0] d, string tag);
    logic [3:0]  expLanes;
    bit          bad;
    bit          expSeq;
    logic [31:0] word;
    logic [1:0]  fl;
    @(negedge clk);
    chk({tag, " R9 rdData"}, rdData, refRd);
    reqXfer = x; reqCopro = cp; reqAddr = a; reqWrite = w; reqSize = sz;
    reqSwap = sw; bigEndian = be; wrData = d;
    #1;
    bad = x && isBad(sz, a);
    expLanes = (x && !bad) ? lanesOf(sz, a, be) : 4'b0000;
    expSeq = x ? (refPrevOk && (a == refPrev || a == refPrev + 2 || a == refPrev + 4)) : cp;
    chk({tag, " R1 memIdle"}, 32'(memIdle), 32'(!x));
    chk({tag, " R2 cycSeq"}, 32'(cycSeq), 32'(expSeq));
    chk({tag, " R4 abort"}, 32'(abort), 32'(bad));
    chk({tag, " R6/R7 laneEn"}, 32'(laneEn), 32'(expLanes));
    chk({tag, " R10 busLock"}, 32'(busLock), 32'(refLock || (x && sw && !bad)));
    // model the clock edge
    fl = firstLane(sz, a, be);
    if (x && !bad && w) begin
      word = refMem[a[7:2]];
      for (int k = 0; k < 4; k++)
        if (expLanes[k]) word[k*8 +: 8] = d[(k - fl)*8 +: 8];
      refMem[a[7:2]] = word;
    end
    if (x && !bad && !w) begin
      word = refMem[a[7:2]] >> (fl * 8);
      refRd = (sz == 2'b00) ? {24'd0, word[7:0]} : (sz == 2'b01) ? {16'd0, word[15:0]} : word;
    end
    if (x && sw && !w && !bad) refLock = 1;
    else if (x && w) refLock = 0;
    refPrevOk = x;
    if (x) refPrev = a;
  endtask

  task automatic idle(bit cp, string tag);
    step(0, cp, 32'h0, 0, 2'b10, 0, 0, 32'h0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R11 busLock after reset", 32'(busLock), 32'd0);
    chk("R11 rdData after reset", rdData, 32'd0);
    // R3: first transfer after reset at address 0 is non-sequential
    for (int i = 0; i < 64; i++)
      step(1, 0, 32'(i * 4), 1, 2'b10, 0, 0, 32'hA500_0000 + 32'(i * 32'h0101), "R3/R8 init");
    // R2 steps
    step(1, 0, 32'h10, 0, 2'b10, 0, 0, 0, "R2 jump");
    step(1, 0, 32'h10, 0, 2'b10, 0, 0, 0, "R2 same");
    step(1, 0, 32'h12, 0, 2'b01, 0, 0, 0, "R2 plus2");
    step(1, 0, 32'h16, 0, 2'b01, 0, 0, 0, "R2 plus4");
    step(1, 0, 32'h1E, 0, 2'b01, 0, 0, 0, "R2 plus8");
    step(1, 0, 32'h1A, 0, 2'b01, 0, 0, 0, "R2 back");
    step(1, 0, 32'hFFFF_FFFC, 0, 2'b10, 0, 0, 0, "R2 top");
    step(1, 0, 32'h0000_0000, 0, 2'b10, 0, 0, 0, "R2 wrap");
    idle(0, "R1 internal");
    step(1, 0, 32'h4, 0, 2'b10, 0, 0, 0, "R3 after internal");
    idle(1, "R1 copro");
    step(1, 0, 32'h4, 0, 2'b10, 0, 0, 0, "R3 after copro");
    // Endian lane maps R6 R7 on word 0x11223344
    step(1, 0, 32'h20, 1, 2'b10, 0, 0, 32'h1122_3344, "R8 word");
    for (int e = 0; e < 2; e++) begin
      for (int b = 0; b < 4; b++)
        step(1, 0, 32'h20 + 32'(b), 0, 2'b00, 0, e[0], 0, "R6/R7 byte");
      step(1, 0, 32'h20, 0, 2'b01, 0, e[0], 0, "R6/R7 half0");
      step(1, 0, 32'h22, 0, 2'b01, 0, e[0], 0, "R6/R7 half2");
      step(1, 0, 32'h22, 1, 2'b01, 0, e[0], 32'hFFFF_BEEF, "R8 half write");
      step(1, 0, 32'h21, 1, 2'b00, 0, e[0], 32'hFFFF_FF5A, "R8 byte write");
      step(1, 0, 32'h20, 0, 2'b10, 0, e[0], 0, "R8 readback");
    end
    // Aborted writes R4 R5
    step(1, 0, 32'h31, 1, 2'b01, 0, 0, 32'hDEAD_DEAD, "R5 odd half");
    step(1, 0, 32'h32, 1, 2'b10, 0, 0, 32'hDEAD_DEAD, "R5 odd word");
    step(1, 0, 32'h30, 1, 2'b11, 0, 0, 32'hDEAD_DEAD, "R5 rsvd");
    step(1, 0, 32'h33, 0, 2'b10, 0, 0, 0, "R5 bad read");
    step(1, 0, 32'h30, 0, 2'b10, 0, 0, 0, "R5 readback");
    // Swap R10
    step(1, 0, 32'h40, 0, 2'b10, 1, 0, 0, "R10 swap rd");
    idle(0, "R10 gap");
    idle(1, "R10 gap copro");
    step(1, 0, 32'h40, 1, 2'b10, 1, 0, 32'h7777_0000, "R10 swap wr");
    idle(0, "R10 released");
    step(1, 0, 32'h41, 0, 2'b10, 1, 0, 0, "R10 aborted swap");
    idle(0, "R10 no hold");
    // Random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r = $urandom;
      logic [31:0] a = {($urandom % 8 == 0) ? 24'hFFFFFF : 24'h0, 8'($urandom)};
      if (r[3:1] == 3'd0) a = refPrev + {29'd0, r[5:4], 1'b0};
      step(r[0] | r[6], r[7], a, r[8], 2'(r[10:9]), r[11], r[12], $urandom, "RND");
    end
    @(negedge clk);
    chk("R9 final rdData", rdData, refRd);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule